// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a cycle-accurate model of a synchronous burst static RAM. The array is small and set by parameters. By default it holds 1024 words of 18 bits, split into two 9-bit byte lanes. Every control and address input is sampled on the rising clock edge. An access begins when one of two address strobes is sampled. From then on, a 2-bit burst sequencer walks the two low address bits through four words. It steps only while the advance input is high, and it holds the current word while advance is low.

Two static mode inputs shape the behaviour, and tying both low gives the default configuration. `linearOrder` selects a wrapping linear sequence or an XOR-interleaved sequence. `flowThrough` selects the read path: data can come straight out of the array, or it can pass through an output register that adds one cycle.

Writes can update selected byte lanes under a byte-write master enable, or every lane through a global write. The processor-side strobe always starts a read. The controller-side strobe lets the write enables choose between read and write. A strobe sampled with chip enable low ends the burst. Output enable gates the bus-drive signal combinationally.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset no burst is active and `dataOutEn` is 0.
- R2: A strobe (`cpuStrobe` or `ctlStrobe`) sampled with `chipEn` high accesses `addr` in that cycle and starts a burst based there. The burst never changes `addr[ADDR_W-1:2]`.
- R3: With `linearOrder`=1, each advance cycle accesses the next word: the low two address bits increment by one, modulo 4.
- R4: With `linearOrder`=0, the k-th word of a burst (k = 0..3) is at low bits equal to the start low bits XOR k.
- R5: In a cycle with no strobe and `advance`=0 during a burst, the same word is accessed again. It is read again, or written again if the write enables are active.
- R6: With `flowThrough`=1, read data from a read sampled at edge t is on `dataOut` with `dataOutEn`=1 between edge t and edge t+1.
- R7: With `flowThrough`=0, that read data appears one cycle later, between edge t+1 and edge t+2. Between edge t and edge t+1 the bus shows the previous cycle's result.
- R8: A write updates byte lane b (bits [9b+8:9b]) when `byteWeMaster`=1 and `byteWe[b]`=1. `globalWe`=1 updates all lanes whatever the byte enables. If `byteWe` is set while both `globalWe` and `byteWeMaster` are 0, the cycle is a read.
- R9: `cpuStrobe` forces a read even when write enables are active, and it wins when both strobes are high.
- R10: A strobe sampled with `chipEn`=0 ends the burst, and later cycles without a new strobe access nothing. The bus is released right after that edge in flow-through mode and one cycle later in pipelined mode.
- R11: `dataOutEn` follows `outEn` combinationally, without waiting for a clock edge.
- R12: A new address can be started on every cycle, with no idle cycle between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of control state |
| cpuStrobe | input | 1 | Processor-side address strobe, always a read |
| ctlStrobe | input | 1 | Controller-side address strobe, read or write |
| advance | input | 1 | Step the burst sequencer |
| chipEn | input | 1 | Chip enable, sampled with a strobe |
| byteWe | input | NUM_BYTES | Per-lane write enables |
| byteWeMaster | input | 1 | Master enable for byte writes |
| globalWe | input | 1 | Write all lanes |
| outEn | input | 1 | Output enable, combinational |
| linearOrder | input | 1 | 1 = linear burst, 0 = interleaved (default) |
| flowThrough | input | 1 | 1 = flow-through reads, 0 = pipelined (default) |
| addr | input | ADDR_W | Word address |
| dataIn | input | NUM_BYTES*BYTE_W | Write data |
| dataOut | output | NUM_BYTES*BYTE_W | Read data, 0 when not driven |
| dataOutEn | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The address and write enables of a cycle take effect at that cycle's edge. So a write shows up in any read issued from the next cycle onward, and a flow-through read is due 5 ns after the edge that sampled it. A pipelined read is due 5 ns after the following edge. Each check of the bench is placed at one of those two points after the edge that sampled the stimulus, and it takes the mode in force into account. In the pipelined sequence the bench first looks at the bus when only the earlier result can be present, and then one cycle later. The output-enable check is made with no clock edge in between.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Per-cycle access strobes passed from control to datapath
  typedef struct packed {
    logic rd;
    logic wr;
  } sbsStrb_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuStrobe,
  input  logic                 ctlStrobe,
  input  logic                 advance,
  input  logic                 chipEn,
  input  logic [NUM_BYTES-1:0] byteWe,
  input  logic                 byteWeMaster,
  input  logic                 globalWe,
  input  logic                 linearOrder,
  input  logic [ADDR_W-1:0]    addr,
  output sbsStrb_t             strb,
  output logic [ADDR_W-1:0]    accAddr,
  output logic [NUM_BYTES-1:0] wrMask
);
  localparam int PAGE_W = ADDR_W - 2;

  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        cnt;
  logic              active;

  logic              anyStrobe, start, cycActive;
  logic [1:0]        cntNext, lowBits;
  logic [ADDR_W-1:0] baseSel;

  always_comb begin
    anyStrobe = cpuStrobe | ctlStrobe;
    start     = anyStrobe & chipEn;
    cycActive = start | (~anyStrobe & active);
    if (start)        cntNext = 2'd0;
    else if (advance) cntNext = cnt + 2'd1;
    else              cntNext = cnt;
    baseSel = start ? addr : baseAddr;
    lowBits = linearOrder ? (baseSel[1:0] + cntNext) : (baseSel[1:0] ^ cntNext);
    accAddr = {baseSel[ADDR_W-1:2], lowBits};
    if (globalWe)          wrMask = '1;
    else if (byteWeMaster) wrMask = byteWe;
    else                   wrMask = '0;
    strb.wr = cycActive & ~cpuStrobe & (|wrMask);
    strb.rd = cycActive & ~strb.wr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      cnt      <= 2'd0;
      active   <= 1'b0;
    end else begin
      if (anyStrobe) active <= chipEn;
      if (start)     baseAddr <= addr;
      if (cycActive) cnt <= cntNext;
    end
  end

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (active && !anyStrobe) |-> accAddr[ADDR_W-1:2] == $past(accAddr[ADDR_W-1:2]));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (active && !anyStrobe && advance && linearOrder && $stable(linearOrder))
      |-> accAddr[1:0] == $past(accAddr[1:0]) + 2'd1);

  assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    (active && !anyStrobe && !advance && $stable(linearOrder))
      |-> accAddr == $past(accAddr));

  assert_deselect_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(anyStrobe && !chipEn) && !anyStrobe) |-> !(strb.rd || strb.wr));

  logic [PAGE_W-1:0] unusedPage;
  assign unusedPage = baseAddr[ADDR_W-1:2];
endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  sbsStrb_t                    strb,
  input  logic [ADDR_W-1:0]           accAddr,
  input  logic [NUM_BYTES-1:0]        wrMask,
  input  logic [NUM_BYTES*BYTE_W-1:0] dataIn,
  input  logic                        flowThrough,
  input  logic                        outEn,
  output logic [NUM_BYTES*BYTE_W-1:0] dataOut,
  output logic                        dataOutEn
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = NUM_BYTES * BYTE_W;

  logic [ADDR_W-1:0] rdAddrQ;
  logic              rdValidQ;
  logic              pipeValid;
  logic [WORD_W-1:0] flowData, pipeData;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gLane
    logic [BYTE_W-1:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.wr && wrMask[g]) lane[accAddr] <= dataIn[g*BYTE_W +: BYTE_W];
    end
    assign flowData[g*BYTE_W +: BYTE_W] = lane[rdAddrQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddrQ   <= '0;
      rdValidQ  <= 1'b0;
      pipeValid <= 1'b0;
      pipeData  <= '0;
    end else begin
      rdAddrQ   <= accAddr;
      rdValidQ  <= strb.rd;
      pipeValid <= rdValidQ;
      pipeData  <= flowData;
    end
  end

  logic selValid;
  always_comb begin
    selValid  = flowThrough ? rdValidQ : pipeValid;
    dataOutEn = outEn & selValid;
    dataOut   = dataOutEn ? (flowThrough ? flowData : pipeData) : '0;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cpuStrobe,
  input  logic                        ctlStrobe,
  input  logic                        advance,
  input  logic                        chipEn,
  input  logic [NUM_BYTES-1:0]        byteWe,
  input  logic                        byteWeMaster,
  input  logic                        globalWe,
  input  logic                        outEn,
  input  logic                        linearOrder,
  input  logic                        flowThrough,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_BYTES*BYTE_W-1:0] dataIn,
  output logic [NUM_BYTES*BYTE_W-1:0] dataOut,
  output logic                        dataOutEn
);
  sbsStrb_t              strb;
  logic [ADDR_W-1:0]     accAddr;
  logic [NUM_BYTES-1:0]  wrMask;

  sbs_ctrl #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuStrobe(cpuStrobe), .ctlStrobe(ctlStrobe),
    .advance(advance), .chipEn(chipEn), .byteWe(byteWe),
    .byteWeMaster(byteWeMaster), .globalWe(globalWe), .linearOrder(linearOrder),
    .addr(addr), .strb(strb), .accAddr(accAddr), .wrMask(wrMask)
  );

  sbs_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .accAddr(accAddr), .wrMask(wrMask),
    .dataIn(dataIn), .flowThrough(flowThrough), .outEn(outEn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  // Edges seen since reset, saturating, to keep $past inside the post-reset window
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_flow_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && flowThrough && outEn) |-> dataOutEn == $past(strb.rd));

  assert_pipe_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && !flowThrough && outEn) |-> dataOutEn == $past(strb.rd, 2));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rstN) |=> !dataOutEn);
endmodule

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuStrobe = 0, ctlStrobe = 0, advance = 0, chipEn = 0;
  logic [1:0]  byteWe = 0;
  logic        byteWeMaster = 0, globalWe = 0, outEn = 1;
  logic        linearOrder = 1, flowThrough = 1;
  logic [9:0]  addr = 0;
  logic [17:0] dataIn = 0;
  logic [17:0] dataOut;
  logic        dataOutEn;

  int vecCount = 0;
  int missCount = 0;

  always #10 clk = ~clk;

  sync_burst_sram dut_i (
    .clk(clk), .rstN(rstN), .cpuStrobe(cpuStrobe), .ctlStrobe(ctlStrobe),
    .advance(advance), .chipEn(chipEn), .byteWe(byteWe), .byteWeMaster(byteWeMaster),
    .globalWe(globalWe), .outEn(outEn), .linearOrder(linearOrder),
    .flowThrough(flowThrough), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  typedef struct packed {
    logic cpu; logic ctl; logic adv; logic ce; logic gw; logic bwm;
    logic [1:0] bw; logic [9:0] a; logic [17:0] d;
    logic expEn; logic [17:0] expD; logic [3:0] req;
  } vec_t;

  // Flow-through, linear order; expected bus state 5 ns after each edge
  localparam vec_t VECS [16] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,10'h010,18'h11111,1'b0,18'h0,4'd8},  // R8 gw start
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,10'h000,18'h22222,1'b0,18'h0,4'd3},  // R3
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,10'h000,18'h33333,1'b0,18'h0,4'd3},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,10'h000,18'h04444,1'b0,18'h0,4'd3},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,10'h012,18'h0,1'b1,18'h33333,4'd6},  // R6 R2
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,10'h000,18'h0,1'b1,18'h04444,4'd3},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,10'h000,18'h0,1'b1,18'h11111,4'd3},  // wrap
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,10'h000,18'h0,1'b1,18'h22222,4'd3},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,10'h000,18'h0,1'b1,18'h22222,4'd5},  // R5
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,2'b01,10'h010,18'h3FFFF,1'b0,18'h0,4'd8},  // byte 0
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,10'h010,18'h0,1'b1,18'h111FF,4'd8},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b11,10'h011,18'h0,1'b1,18'h22222,4'd8},  // no master
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,10'h013,18'h0,1'b1,18'h04444,4'd9},  // R9
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,10'h012,18'h0,1'b1,18'h33333,4'd12}, // R12
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,10'h000,18'h0,1'b0,18'h0,4'd10},     // R10
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,10'h000,18'h0,1'b0,18'h0,4'd10}
  };

  task automatic check(input string req, input logic expEn, input logic [17:0] expD);
    vecCount++;
    if (dataOutEn !== expEn || (expEn && dataOut !== expD)) begin
      missCount++;
      $display("FAIL %s: en=%b data=%h expected en=%b data=%h",
               req, dataOutEn, dataOut, expEn, expD);
    end
  endtask

  task automatic step(input logic c, input logic t, input logic v, input logic e,
                      input logic g, input logic m, input logic [1:0] b,
                      input logic [9:0] a, input logic [17:0] d);
    @(negedge clk);
    cpuStrobe = c; ctlStrobe = t; advance = v; chipEn = e;
    globalWe = g; byteWeMaster = m; byteWe = b; addr = a; dataIn = d;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(20 * 20000);
    missCount++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1", 1'b0, 18'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 16; i++) begin
      step(VECS[i].cpu, VECS[i].ctl, VECS[i].adv, VECS[i].ce, VECS[i].gw,
           VECS[i].bwm, VECS[i].bw, VECS[i].a, VECS[i].d);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].expEn, VECS[i].expD);
    end

    // R4: interleaved write burst from 0x41 lands at 41,40,43,42
    linearOrder = 1'b0;
    step(0,1,0,1,1,0,2'b00,10'h041,18'h0A0A0);
    step(0,0,1,0,1,0,2'b00,10'h000,18'h0B0B0);
    step(0,0,1,0,1,0,2'b00,10'h000,18'h0C0C0);
    step(0,0,1,0,1,0,2'b00,10'h000,18'h0D0D0);
    step(1,0,0,1,0,0,2'b00,10'h040,18'h0);
    check("R4 word0", 1'b1, 18'h0B0B0);
    step(0,0,1,0,0,0,2'b00,10'h000,18'h0);
    check("R4 word1", 1'b1, 18'h0A0A0);
    step(0,0,1,0,0,0,2'b00,10'h000,18'h0);
    check("R4 word2", 1'b1, 18'h0D0D0);
    step(0,0,1,0,0,0,2'b00,10'h000,18'h0);
    check("R4 word3", 1'b1, 18'h0C0C0);
    step(0,1,0,0,0,0,2'b00,10'h000,18'h0);
    check("R10 flow release", 1'b0, 18'h0);

    // R7: pipelined latency and deselect one cycle later
    flowThrough = 1'b0;
    step(1,0,0,1,0,0,2'b00,10'h043,18'h0);
    check("R7 not yet", 1'b0, 18'h0);
    step(1,0,0,1,0,0,2'b00,10'h012,18'h0);
    check("R7 first", 1'b1, 18'h0C0C0);
    step(0,1,0,0,0,0,2'b00,10'h000,18'h0);
    check("R7 R12 second", 1'b1, 18'h33333);
    step(0,0,0,0,0,0,2'b00,10'h000,18'h0);
    check("R10 pipe release", 1'b0, 18'h0);

    // R11: output enable acts without a clock edge
    flowThrough = 1'b1;
    @(negedge clk); outEn = 1'b0;
    step(1,0,0,1,0,0,2'b00,10'h010,18'h0);
    check("R11 oe low", 1'b0, 18'h0);
    outEn = 1'b1;
    #1;
    check("R11 oe high", 1'b1, 18'h111FF);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule